// File: doc/BRIEF.md
# Greedy Collision-Vector Task Admission Controller

This block guards the entry of a multi-stage pipeline whose stages may be visited more than once by a single task. It decides, in every cycle, whether a new task may start without two tasks ever needing the same stage in the same cycle. The decision uses a reservation register. Bit k of that register means that starting a task k+1 cycles from now would collide with a task already in flight.

Task requests arrive as one-cycle pulses on `req_i`. They are counted in a backlog, so several requests can wait at the same time. Whenever the backlog is non-empty and the next slot is free, the controller starts a task at once, which gives greedy initiation. Accepting a task merges the pipeline's own forbidden-latency pattern (parameter `INIT_CV`) into the reservation register. Two free-running counters, one for accepted tasks and one for elapsed cycles, allow throughput to be measured from outside.

Top module: `cvpi_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `accept_o` and `busy_o` are 0 and both counters read 0. The reservation register and the backlog are empty.
- R2: Bit k of the reservation register marks start distance k+1 as forbidden. Every clock the register moves one position toward bit 0, and a 0 enters at the top bit.
- R3: `accept_o` is 1 exactly when work is waiting (a request this cycle or a non-empty backlog) and reservation bit 0 is clear. On an accept, `INIT_CV` is ORed into the moved register. Bit 0 of `INIT_CV` stands for distance 1 and bit CV_W-1 for distance CV_W.
- R4: The controller is greedy. A waiting task is accepted in the first cycle that R3 permits. With an empty pipeline, a request is accepted in the same cycle it arrives.
- R5: A request that cannot be accepted stays in the backlog; requests in consecutive cycles are all counted. `accept_o` never rises without waiting work, and each accept removes one task.
- R6: With `INIT_CV` = 5'b10011 (distances 1, 2 and 5 forbidden) and a constant backlog, tasks start every 3 cycles. Four requests in cycles 0–3 start in cycles 0, 3, 6 and 9.
- R7: With `INIT_CV` = 6'b101010 (distances 2, 4 and 6 forbidden) and a constant backlog, start distances alternate 1 and 7. Six requests in cycles 0–5 start in cycles 0, 1, 8, 9, 16 and 17.
- R8: `busy_o` is 1 while the backlog or the reservation register is non-zero. In the six-task run of R7 it reads 1 in cycle 23 and 0 in cycle 24.
- R9: `acc_cnt_o` rises by one on the clock edge that ends each accepting cycle.
- R10: `cyc_cnt_o` rises by one on every clock edge after reset is released.
- R11: No accepted start lies at a forbidden distance from any earlier accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle pulse: one new task wants to start |
| accept_o | output | 1 | A task starts in this cycle |
| busy_o | output | 1 | Backlog or reservation register non-empty |
| acc_cnt_o | output | CNT_W | Number of tasks accepted since reset |
| cyc_cnt_o | output | CNT_W | Clock cycles since reset release |

## Verification
`accept_o` is combinational. It answers a request in the same cycle it is driven, so the bench drives `req_i` on the falling edge and samples `accept_o` 5 ns later, before the next rising edge. `busy_o` and both counters depend only on registers. They show the effect of a cycle's accept one rising edge later, so a count checked in cycle t covers accepts in cycles 0 to t-1. A reference model in the bench keeps its own backlog and start history. It tests every candidate start against the forbidden distances in that history, and it runs both configurations side by side.

// File: rtl/cvpi_pkg.sv
package cvpi_pkg;
    localparam int CVPI_CV_W_DEF   = 5;
    localparam int CVPI_PEND_W_DEF = 4;
    localparam int CVPI_CNT_W_DEF  = 16;
endpackage

// File: rtl/cvpi_state.sv
module cvpi_state #(
    parameter int              CV_W    = cvpi_pkg::CVPI_CV_W_DEF,
    parameter logic [CV_W-1:0] INIT_CV = 5'b10011
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic accept_i,
    output logic slot_busy_o,
    output logic idle_o
);
    typedef struct packed {
        logic [CV_W-1:0] rsv;
    } state_t;

    state_t          st_d, st_q;
    logic [CV_W-1:0] aged;

    for (genvar k = 0; k < CV_W; k++) begin : g_age
        if (k == CV_W - 1) begin : g_top
            assign aged[k] = 1'b0;
        end else begin : g_mid
            assign aged[k] = st_q.rsv[k+1];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.rsv = aged | (accept_i ? INIT_CV : '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign slot_busy_o = st_q.rsv[0];
    assign idle_o      = (st_q.rsv == '0);

    AST_MERGE_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_i |=> ((st_q.rsv & INIT_CV) == INIT_CV)); // R3
    AST_SHIFT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !accept_i |=> (st_q.rsv == ($past(st_q.rsv) >> 1))); // R2
    AST_SLOT_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_i |-> !st_q.rsv[0]); // R11
endmodule

// File: rtl/cvpi_backlog.sv
module cvpi_backlog #(
    parameter int PEND_W = cvpi_pkg::CVPI_PEND_W_DEF
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic accept_i,
    output logic work_o,
    output logic pend_nz_o
);
    typedef struct packed {
        logic [PEND_W-1:0] cnt;
    } bl_t;

    bl_t bl_d, bl_q;

    always_comb begin
        bl_d     = bl_q;
        bl_d.cnt = bl_q.cnt + PEND_W'(req_i) - PEND_W'(accept_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bl_q <= '0;
        else         bl_q <= bl_d;
    end

    assign pend_nz_o = (bl_q.cnt != '0);
    assign work_o    = req_i | pend_nz_o;

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !accept_i) |-> (bl_q.cnt != '1)); // R5
    AST_ACC_HAS_WORK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_i |-> (req_i || bl_q.cnt != '0)); // R5
    AST_WAIT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !accept_i) |=> (bl_q.cnt != '0)); // R5
endmodule

// File: rtl/cvpi_counters.sv
module cvpi_counters #(
    parameter int CNT_W = cvpi_pkg::CVPI_CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             accept_i,
    output logic [CNT_W-1:0] acc_o,
    output logic [CNT_W-1:0] cyc_o
);
    typedef struct packed {
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] cyc;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.cyc = c_q.cyc + 1'b1;
        if (accept_i) c_d.acc = c_q.acc + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign acc_o = c_q.acc;
    assign cyc_o = c_q.cyc;

    AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_i |=> (c_q.acc == CNT_W'($past(c_q.acc) + 1'b1))); // R9
    AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !accept_i |=> $stable(c_q.acc)); // R9
    AST_CYC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (c_q.cyc == CNT_W'($past(c_q.cyc) + 1'b1))); // R10
endmodule

// File: rtl/cvpi_ctrl.sv
module cvpi_ctrl #(
    parameter int              CV_W    = cvpi_pkg::CVPI_CV_W_DEF,
    parameter logic [CV_W-1:0] INIT_CV = 5'b10011,
    parameter int              PEND_W  = cvpi_pkg::CVPI_PEND_W_DEF,
    parameter int              CNT_W   = cvpi_pkg::CVPI_CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic [CNT_W-1:0] acc_cnt_o,
    output logic [CNT_W-1:0] cyc_cnt_o
);
    logic slot_busy, rsv_idle, work, pend_nz;

    cvpi_state #(.CV_W(CV_W), .INIT_CV(INIT_CV)) u_state (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .accept_i    (accept_o),
        .slot_busy_o (slot_busy),
        .idle_o      (rsv_idle)
    );

    cvpi_backlog #(.PEND_W(PEND_W)) u_backlog (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (req_i),
        .accept_i  (accept_o),
        .work_o    (work),
        .pend_nz_o (pend_nz)
    );

    cvpi_counters #(.CNT_W(CNT_W)) u_counters (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .accept_i (accept_o),
        .acc_o    (acc_cnt_o),
        .cyc_o    (cyc_cnt_o)
    );

    assign accept_o = work & ~slot_busy;
    assign busy_o   = pend_nz | ~rsv_idle;

    AST_IDLE_TAKES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && req_i) |-> accept_o); // R4
    AST_BUSY_AFTER_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept_o && (INIT_CV != '0)) |=> busy_o); // R8
    AST_NO_IDLE_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !req_i) |-> !accept_o); // R5
endmodule

// File: tb/cvpi_ctrl_bench.sv
`timescale 1ns/1ps
module cvpi_ctrl_bench;
    localparam logic [4:0] CV_A = 5'b10011;
    localparam logic [5:0] CV_B = 6'b101010;

    // {req, expected accept} for the default configuration, from reset
    localparam logic [1:0] TAB_A [16] = '{
        2'b11, 2'b10, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 2'b11,
        2'b10, 2'b10, 2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_a = 1'b0, req_b = 1'b0;
    logic        acc_a, acc_b, busy_a, busy_b;
    logic [15:0] acnt_a, acnt_b, ccnt_a, ccnt_b;

    always #10 clk = ~clk;

    cvpi_ctrl u_cvpi_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req_a), .accept_o(acc_a),
        .busy_o(busy_a), .acc_cnt_o(acnt_a), .cyc_cnt_o(ccnt_a));

    cvpi_ctrl #(.CV_W(6), .INIT_CV(CV_B)) u_cvpi_ctrl_alt (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req_b), .accept_o(acc_b),
        .busy_o(busy_b), .acc_cnt_o(acnt_b), .cyc_cnt_o(ccnt_b));

    int checks = 0, fails = 0, cyc = -1;
    int pa, pb, na, nb, ca, cb;
    int hist_a [64], hist_b [64], cap_a [64], cap_b [64];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    task automatic clear_ref();
        pa = 0; pb = 0; na = 0; nb = 0; ca = 0; cb = 0; cyc = -1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; req_a = 1'b0; req_b = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        clear_ref();
        #1;
        chk(acc_a == 0 && busy_a == 0, "R1 ctrl A", {acc_a, busy_a}, 0);
        chk(acnt_a == 0 && ccnt_a == 0, "R1 counters A", acnt_a + ccnt_a, 0);
        chk(acc_b == 0 && busy_b == 0 && acnt_b == 0 && ccnt_b == 0, "R1 B", busy_b, 0);
    endtask

    // One cycle: drive, then compare both instances with the reference model (R11, R4)
    task automatic tick(input logic ra, input logic rb);
        bit ok_a, ok_b;
        @(negedge clk); req_a = ra; req_b = rb; cyc++; #5;
        pa += int'(ra); pb += int'(rb);
        ok_a = (pa > 0);
        for (int i = 0; i < na; i++) begin
            int d = cyc - hist_a[i];
            if (d >= 1 && d <= 5 && CV_A[d-1]) ok_a = 1'b0;
        end
        ok_b = (pb > 0);
        for (int i = 0; i < nb; i++) begin
            int d = cyc - hist_b[i];
            if (d >= 1 && d <= 6 && CV_B[d-1]) ok_b = 1'b0;
        end
        chk(acc_a == ok_a, "R11 ref model A", acc_a, ok_a);
        chk(acc_b == ok_b, "R11 ref model B", acc_b, ok_b);
        if (ok_a) begin hist_a[na] = cyc; na++; pa--; end
        if (ok_b) begin hist_b[nb] = cyc; nb++; pb--; end
        if (acc_a && ca < 64) begin cap_a[ca] = cyc; ca++; end
        if (acc_b && cb < 64) begin cap_b[cb] = cyc; cb++; end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(20 * 5000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();

        // Vector table: waiting requests, same-cycle accept (R3, R4, R5)
        for (int i = 0; i < 16; i++) begin
            tick(TAB_A[i][1], 1'b0);
            chk(acc_a == TAB_A[i][0], "R3 R5 table accept", acc_a, TAB_A[i][0]);
        end
        chk(acnt_a == 16'd5, "R9 accepted count", acnt_a, 5);
        chk(ccnt_a == 16'd15, "R10 cycle count", ccnt_a, 15);
        chk(acc_b == 0 && busy_b == 0, "R5 idle instance stays quiet", acc_b, 0);
        // last start in cycle 13: reservations drain by cycle 19 (R2, R8)
        tick(1'b0, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
        chk(busy_a == 1'b1, "R2 R8 busy while draining", busy_a, 1);
        tick(1'b0, 1'b0);
        chk(busy_a == 1'b0, "R2 R8 idle after drain", busy_a, 0);

        // Backlog runs on both configurations (R6, R7, R8)
        do_reset();
        for (int t = 0; t < 25; t++) begin
            tick(t < 4, t < 6);
            if (t == 23) chk(busy_b == 1'b1, "R8 busy cycle 23", busy_b, 1);
            if (t == 24) chk(busy_b == 1'b0, "R8 idle cycle 24", busy_b, 0);
        end
        chk(ca == 4, "R6 start count", ca, 4);
        for (int i = 0; i < 4 && i < ca; i++)
            chk(cap_a[i] == 3 * i, "R6 start cycle", cap_a[i], 3 * i);
        chk(cb == 6, "R7 start count", cb, 6);
        for (int i = 0; i < 6 && i < cb; i++)
            chk(cap_b[i] == 8 * (i / 2) + (i % 2), "R7 start cycle", cap_b[i], 8 * (i / 2) + (i % 2));
        chk(acnt_b == 16'd6, "R9 accepted count B", acnt_b, 6);
        chk(ccnt_b == 16'd24, "R10 cycle count B", ccnt_b, 24);

        // Reset in the middle of activity, then immediate accept (R1, R4)
        tick(1'b1, 1'b1); tick(1'b1, 1'b1);
        @(negedge clk); rst_n = 1'b0; req_a = 1'b0; req_b = 1'b0; #5;
        chk(busy_a == 0 && busy_b == 0 && acnt_a == 0 && ccnt_b == 0, "R1 async clear", busy_a, 0);
        @(posedge clk); #2 rst_n = 1'b1; clear_ref();
        tick(1'b1, 1'b1);
        chk(acc_a == 1'b1 && acc_b == 1'b1, "R4 empty accepts at once", {acc_a, acc_b}, 3);
        tick(1'b1, 1'b1);
        chk(acc_a == 1'b0, "R3 distance 1 forbidden A", acc_a, 0);
        chk(acc_b == 1'b1, "R3 distance 1 allowed B", acc_b, 1);

        summary();
        $finish;
    end
endmodule